// File: doc/BRIEF.md
# Fan Tachometer Measurement Unit

This block measures fan speed from a tachometer input. The input passes through a two-flop synchroniser, and only its rising edges are counted. They are counted over a measurement window that repeats without a gap. The window is either 250 ms or 1 s long. Time is derived from a prescaler that is set by the parameter `CYC_PER_MS` (clock cycles per millisecond).

When a window closes, the edge count is divided by the number of pulses the fan gives per revolution, which is 2 or 4. The quotient, in revolutions per window, is latched into the tach-data output and the counter starts again from zero. In the same cycle the block raises a stall flag if the window saw no edge at all. It also compares the new value with a low limit and a high limit to produce an RPM alarm.

Clearing the enable freezes the whole measurement: the prescaler, the window position, the edge count and the published result all hold their values. Input edges seen while the enable is clear are ignored. A measurement-active output tells the PWM stage to keep the fan powered while pulses are being counted. The block's internal logic is reset asynchronously, and the reset is released synchronously to the clock.

Top module: `fan_tach_meter`

## Requirements
- R1: While reset is asserted, and until the first window closes, `tach_data`, `stall` and `rpm_alarm` are 0. `meas_active` is 0 while reset is asserted.
- R2: `tach_in` passes through a two-flop synchroniser. Only 0-to-1 transitions are counted, so a pulse held high for many cycles counts as one edge.
- R3: When a window closes, the result is floor(edges/2) if `ppr_sel`=0 and floor(edges/4) if `ppr_sel`=1.
- R4: While enabled, a window lasts 250×`CYC_PER_MS` clock cycles when `fast_sel`=1 and 1000×`CYC_PER_MS` when `fast_sel`=0. Windows follow one another with no gap, and the counter restarts at each window close.
- R5: While `tach_en`=0, edges are ignored, and the prescaler, the window position, the edge count and `tach_data` all hold. Counting resumes from the held state when `tach_en` returns to 1.
- R6: When a window closes, `stall` becomes 1 if the window counted zero edges and 0 otherwise. It holds until the next window closes.
- R7: When a window closes, `rpm_alarm` becomes 1 if the new result is below `lo_limit` or above `hi_limit`. A result equal to either limit gives 0. The flag holds until the next window closes.
- R8: `meas_active` equals (`tach_en` AND NOT `tach_mode`), registered one cycle.
- R9: The edge counter saturates instead of wrapping, and a result above the range of `tach_data` is clamped to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | 1 | Asynchronous tachometer pulse input |
| ppr_sel | input | 1 | 0: 2 pulses per revolution, 1: 4 pulses per revolution |
| fast_sel | input | 1 | 1: 250 ms window, 0: 1 s window |
| tach_en | input | 1 | 1: measure, 0: freeze |
| tach_mode | input | 1 | 0: request fan power during counting |
| lo_limit | input | DW | Low limit for the result |
| hi_limit | input | DW | High limit for the result |
| tach_data | output | DW | Revolutions in the last window |
| stall | output | 1 | Last window saw no edge |
| rpm_alarm | output | 1 | Last result was outside the limits |
| meas_active | output | 1 | Counting with forced fan power |

## Verification
Every cycle, the assertions check the following:
- the prescaler and the window position stay in range;
- the window position restarts after each close;
- a synchronised rise never lasts two cycles;
- the edge count never drops inside a window;
- everything holds while the block is disabled;
- a raised stall comes with a zero result;
- the alarm agrees with the latched result and the limits.

Only the bench scenarios can show the rest:
- the exact window lengths in both modes;
- the division for 2 and 4 pulses per revolution, including truncation;
- the inclusive limits;
- the clamping when the fan is fast;
- a measurement that resumes correctly after a freeze.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int FAST_MS = 250;
  localparam int SLOW_MS = 1000;

  typedef enum logic {
    PPR_TWO  = 1'b0,
    PPR_FOUR = 1'b1
  } ppr_e;
endpackage

// File: rtl/tach_rst_sync.sv
module tach_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_core_n = stage_q[1];
endmodule

// File: rtl/tach_sync_edge.sv
module tach_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_in,
  output logic rise
);
  logic [STAGES:0] shift_q;
  logic [STAGES:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-1:0], tach_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rise = shift_q[STAGES-1] & ~shift_q[STAGES];

  // R2: a level held high yields a single-cycle rise
  p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tach_timebase.sv
module tach_timebase
  import tach_pkg::*;
#(
  parameter int CYC_PER_MS = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fast,
  output logic win_end
);
  localparam int PW  = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam int MSW = $clog2(SLOW_MS);
  localparam logic [PW-1:0]  PRE_LAST  = PW'(CYC_PER_MS - 1);
  localparam logic [MSW-1:0] FAST_LAST = MSW'(FAST_MS - 1);
  localparam logic [MSW-1:0] SLOW_LAST = MSW'(SLOW_MS - 1);

  logic [PW-1:0]  pre_q, pre_d;
  logic [MSW-1:0] ms_q, ms_d;
  logic           ms_tick;
  logic [MSW-1:0] ms_last;

  always_comb begin
    ms_last = fast ? FAST_LAST : SLOW_LAST;
    ms_tick = en && (pre_q == PRE_LAST);
    win_end = ms_tick && (ms_q >= ms_last);
    pre_d   = pre_q;
    ms_d    = ms_q;
    if (en) begin
      pre_d = ms_tick ? '0 : pre_q + 1'b1;
    end
    if (ms_tick) begin
      ms_d = win_end ? '0 : ms_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end

  // R4: prescaler and window position stay in range
  p_pre_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre_q) < CYC_PER_MS);
  p_ms_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ms_q) < SLOW_MS);
  // R4: the window restarts after it closes
  p_end_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (ms_q == '0 && pre_q == '0));
  // R5: the timebase holds while disabled
  p_time_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(pre_q) && $stable(ms_q)));
endmodule

// File: rtl/tach_accum.sv
module tach_accum
  import tach_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = DW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rise,
  input  logic          win_end,
  input  ppr_e          ppr,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic [DW-1:0] data,
  output logic          stall,
  output logic          alarm
);
  localparam logic [CW-1:0] CNT_MAX  = '1;
  localparam logic [CW-1:0] DATA_MAX = CW'((64'd1 << DW) - 64'd1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] total;
  logic [CW-1:0] quot;
  logic [DW-1:0] norm;
  logic [DW-1:0] data_q, data_d;
  logic          stall_q, stall_d;
  logic          alarm_q, alarm_d;

  always_comb begin
    total = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CW'(rise);
    quot  = (ppr == PPR_FOUR) ? (total >> 2) : (total >> 1);
    norm  = (quot > DATA_MAX) ? DATA_MAX[DW-1:0] : quot[DW-1:0];

    cnt_d   = cnt_q;
    data_d  = data_q;
    stall_d = stall_q;
    alarm_d = alarm_q;
    if (en) begin
      if (win_end) begin
        cnt_d   = '0;
        data_d  = norm;
        stall_d = (total == '0);
        alarm_d = (norm < lo) || (norm > hi);
      end else begin
        cnt_d = total;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      data_q  <= '0;
      stall_q <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      data_q  <= data_d;
      stall_q <= stall_d;
      alarm_q <= alarm_d;
    end
  end

  assign data  = data_q;
  assign stall = stall_q;
  assign alarm = alarm_q;

  // R5: counting and the published result hold while disabled
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt_q) && $stable(data_q)));
  // R9: inside a window the count never wraps back
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !win_end) |=> (cnt_q >= $past(cnt_q)));
  // R6: a stalled window always publishes zero
  p_stall_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q |-> (data_q == '0));
  // R7: the alarm agrees with the latched result and the limits
  p_alarm_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && win_end) |=> (alarm_q == ((data_q < $past(lo)) || (data_q > $past(hi)))));
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import tach_pkg::*;
#(
  parameter int CYC_PER_MS = 25000,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tach_in,
  input  logic          ppr_sel,
  input  logic          fast_sel,
  input  logic          tach_en,
  input  logic          tach_mode,
  input  logic [DW-1:0] lo_limit,
  input  logic [DW-1:0] hi_limit,
  output logic [DW-1:0] tach_data,
  output logic          stall,
  output logic          rpm_alarm,
  output logic          meas_active
);
  localparam int CW = DW + 3;

  logic rst_core_n;
  logic rise;
  logic win_end;
  logic meas_q, meas_d;
  ppr_e ppr;

  assign ppr = ppr_e'(ppr_sel);

  tach_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  tach_sync_edge #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tach_in (tach_in),
    .rise    (rise)
  );

  tach_timebase #(.CYC_PER_MS(CYC_PER_MS)) u_time (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .en      (tach_en),
    .fast    (fast_sel),
    .win_end (win_end)
  );

  tach_accum #(.DW(DW), .CW(CW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .en      (tach_en),
    .rise    (rise),
    .win_end (win_end),
    .ppr     (ppr),
    .lo      (lo_limit),
    .hi      (hi_limit),
    .data    (tach_data),
    .stall   (stall),
    .alarm   (rpm_alarm)
  );

  always_comb begin
    meas_d = tach_en & ~tach_mode;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) meas_q <= 1'b0;
    else             meas_q <= meas_d;
  end

  assign meas_active = meas_q;

  // R8: fan power is never requested while frozen
  p_meas_off_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !tach_en |=> !meas_active);
endmodule

// File: tb/sim_fan_tach_meter.sv
`timescale 1ns/1ps
module sim_fan_tach_meter;
  localparam int P    = 4;
  localparam int DW   = 8;
  localparam int CMAX = 2047;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tach_in = 1'b0, ppr_sel = 1'b0, fast_sel = 1'b1, tach_en = 1'b1, tach_mode = 1'b0;
  logic [DW-1:0] lo_limit = 8'd10, hi_limit = 8'd100;
  logic [DW-1:0] tach_data;
  logic stall, rpm_alarm, meas_active;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fan_tach_meter #(.CYC_PER_MS(P), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .ppr_sel(ppr_sel),
    .fast_sel(fast_sel), .tach_en(tach_en), .tach_mode(tach_mode),
    .lo_limit(lo_limit), .hi_limit(hi_limit), .tach_data(tach_data),
    .stall(stall), .rpm_alarm(rpm_alarm), .meas_active(meas_active)
  );

  // behavioural reference state
  int rs1 = 0, rs2 = 0;
  int s1 = 0, s2 = 0, s3 = 0;
  int pre = 0, ms = 0, cnt = 0;
  int m_data = 0, m_stall = 0, m_alarm = 0, m_meas = 0, upd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rs1 = 0; rs2 = 0; s1 = 0; s2 = 0; s3 = 0; pre = 0; ms = 0; cnt = 0;
      m_data = 0; m_stall = 0; m_alarm = 0; m_meas = 0;
    end else begin
      if (rs2 != 0) begin
        int rise, tick, lim, wend, tot, n;
        rise = (s2 != 0 && s3 == 0) ? 1 : 0;
        s3 = s2; s2 = s1; s1 = int'(tach_in);
        m_meas = (tach_en && !tach_mode) ? 1 : 0;
        if (tach_en) begin
          tick = (pre == P - 1) ? 1 : 0;
          pre  = tick ? 0 : pre + 1;
          lim  = fast_sel ? 250 : 1000;
          wend = (tick && ms >= lim - 1) ? 1 : 0;
          if (tick) ms = wend ? 0 : ms + 1;
          tot = (cnt == CMAX) ? cnt : cnt + rise;
          if (wend) begin
            n = ppr_sel ? tot / 4 : tot / 2;
            if (n > 255) n = 255;
            m_alarm = (n < int'(lo_limit) || n > int'(hi_limit)) ? 1 : 0;
            m_stall = (tot == 0) ? 1 : 0;
            m_data  = n;
            cnt = 0;
            upd++;
          end else begin
            cnt = tot;
          end
        end
      end
      rs2 = rs1; rs1 = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("R3 tach_data vs model", int'(tach_data), m_data);
      chk("R6 stall vs model", int'(stall), m_stall);
      chk("R7 rpm_alarm vs model", int'(rpm_alarm), m_alarm);
      chk("R8 meas_active vs model", int'(meas_active), m_meas);
    end
  end

  task automatic pulse(int n, int h, int l);
    for (int i = 0; i < n; i++) begin
      tach_in = 1'b1; repeat (h) @(negedge clk);
      tach_in = 1'b0; repeat (l) @(negedge clk);
    end
  endtask

  task automatic wait_upd();
    int u;
    u = upd;
    while (upd == u) @(negedge clk);
  endtask

  task automatic sync_win();
    @(negedge clk);
    while (!(ms == 0 && pre == 0)) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000 - 50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 data in reset", int'(tach_data), 0);
    chk("R1 stall in reset", int'(stall), 0);
    chk("R1 alarm in reset", int'(rpm_alarm), 0);
    chk("R1 meas in reset", int'(meas_active), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 data before first window", int'(tach_data), 0);

    // R3 two pulses per revolution, fast window
    sync_win();
    pulse(40, 5, 5);
    wait_upd();
    chk("R3 40 edges ppr2", int'(tach_data), 20);
    chk("R7 in range", int'(rpm_alarm), 0);
    chk("R6 not stalled", int'(stall), 0);
    wait_upd();
    chk("R6 empty window stall", int'(stall), 1);
    chk("R7 below low alarm", int'(rpm_alarm), 1);

    // R3 four pulses per revolution, R7 low limit inclusive
    ppr_sel = 1'b1;
    sync_win();
    pulse(40, 3, 3);
    wait_upd();
    chk("R3 40 edges ppr4", int'(tach_data), 10);
    chk("R7 equal to low limit", int'(rpm_alarm), 0);

    // R3 truncation, R7 above high
    hi_limit = 8'd9;
    sync_win();
    pulse(41, 3, 3);
    wait_upd();
    chk("R3 41 edges ppr4 floor", int'(tach_data), 10);
    chk("R7 above high alarm", int'(rpm_alarm), 1);

    // R2 long pulses count once
    hi_limit = 8'd100; ppr_sel = 1'b0;
    sync_win();
    pulse(5, 50, 50);
    wait_upd();
    chk("R2 long high pulses", int'(tach_data), 2);

    // R5 freeze
    sync_win();
    d0 = int'(tach_data);
    pulse(20, 3, 3);
    tach_en = 1'b0;
    pulse(30, 3, 3);
    repeat (2000) @(negedge clk);
    chk("R5 data held while frozen", int'(tach_data), d0);
    chk("R8 meas off while frozen", int'(meas_active), 0);
    tach_en = 1'b1;
    pulse(20, 3, 3);
    wait_upd();
    chk("R5 resumed count", int'(tach_data), 20);

    // R4 slow window length
    fast_sel = 1'b0;
    sync_win();
    d0 = int'(tach_data);
    pulse(100, 3, 3);
    repeat (2900) @(negedge clk);
    chk("R4 slow window still open", int'(tach_data), d0);
    repeat (600) @(negedge clk);
    chk("R4 slow window closed", int'(tach_data), 50);

    // R9 clamp
    sync_win();
    for (int i = 0; i < 3900; i++) begin
      tach_in = ~tach_in;
      @(negedge clk);
    end
    tach_in = 1'b0;
    wait_upd();
    chk("R9 clamped result", int'(tach_data), 255);
    chk("R7 clamp above high", int'(rpm_alarm), 1);

    // R8 mode control
    tach_mode = 1'b1; repeat (2) @(negedge clk);
    chk("R8 mode 1 no force", int'(meas_active), 0);
    tach_mode = 1'b0; repeat (2) @(negedge clk);
    chk("R8 mode 0 force", int'(meas_active), 1);

    summary();
  end
endmodule